// File: doc/BRIEF.md
# Dual-Clock FIFO Flag Timing Stage

This block sits between the flag logic of a dual-clock FIFO and the pins that report those flags. It receives four raw conditions that other logic has already computed: empty, full, almost-empty and almost-full. It turns them into four output flags, using timing options that are captured while reset is held. All flags are active high: a 1 means the condition is present.

The almost flags can run in one of two timing modes:
- **Split-edge mode.** Each almost flag is set by a rising edge of one clock and cleared by a rising edge of the other clock.
- **Single-owner mode.** Each almost flag follows its raw condition, sampled only on the clock of the side that owns it.

The empty flag is retimed in the read-clock domain. The full flag is retimed in the write-clock domain. Each of the two can pass through one, two or three register stages. This trades response time for settling margin at the boundary states. Only certain pairings of the two depths are allowed. Any other pairing makes both flags fall back to a single stage.

Top module: `flag_timing_stage`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is low and both clocks are running, the outputs read `empty`=1, `almost_empty`=1, `full`=0 and `almost_full`=0.
- R2: The configuration inputs are captured on clock edges only while `rst_n` is low. Changing them after reset has been released has no effect on flag latency or on flag timing mode.
- R3: `empty` equals the value of `raw_empty` sampled N `rd_clk` rising edges earlier. N is 1, 2 or 3 for `cfg_empty_buf` codes 0, 1 or 2. Edges of `wr_clk` never change `empty`.
- R4: `full` equals the value of `raw_full` sampled N `wr_clk` rising edges earlier. N is 1, 2 or 3 for `cfg_full_buf` codes 0, 1 or 2. Edges of `rd_clk` never change `full`.
- R5: A pair of depth codes is supported when both codes are below 3 and either code is 0 or the two codes are equal. For any other pair, both `empty` and `full` use a single stage (N=1).
- R6: With `cfg_async_almost`=0, `almost_empty` equals `raw_almost_empty` as sampled at the most recent `rd_clk` rising edge. `wr_clk` edges never change it.
- R7: With `cfg_async_almost`=0, `almost_full` equals `raw_almost_full` as sampled at the most recent `wr_clk` rising edge. `rd_clk` edges never change it.
- R8: With `cfg_async_almost`=1:
  - `almost_empty` goes to 1 only on a `rd_clk` rising edge where `raw_almost_empty` is 1.
  - It goes to 0 only on a `wr_clk` rising edge where `raw_almost_empty` is 0.
- R9: With `cfg_async_almost`=1:
  - `almost_full` goes to 1 only on a `wr_clk` rising edge where `raw_almost_full` is 1.
  - It goes to 0 only on a `rd_clk` rising edge where `raw_almost_full` is 0.
- R10: The almost flags take no extra register stages, whatever the depth codes are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, seen by both clocks |
| cfg_async_almost | input | 1 | 1 selects split-edge timing for the almost flags |
| cfg_empty_buf | input | 2 | Empty flag depth code (0/1/2 = 1/2/3 stages, 3 reserved) |
| cfg_full_buf | input | 2 | Full flag depth code (0/1/2 = 1/2/3 stages, 3 reserved) |
| raw_empty | input | 1 | Raw empty condition |
| raw_full | input | 1 | Raw full condition |
| raw_almost_empty | input | 1 | Raw almost-empty condition |
| raw_almost_full | input | 1 | Raw almost-full condition |
| empty | output | 1 | Timed empty flag |
| full | output | 1 | Timed full flag |
| almost_empty | output | 1 | Timed almost-empty flag |
| almost_full | output | 1 | Timed almost-full flag |

## Verification
The stimulus changes one raw condition at a time. It then advances the two clocks one edge at a time, with the edge of the clock that should not matter applied first. This shows which domain owns each transition of each flag.

Depth tests step the clock one edge at a time until the boundary flag moves. Running all three codes separates a single-, double- and triple-stage path. Mixed and reserved code pairs separate the fallback from a normal decode. Configuration values changed after reset show whether the options are latched only during reset.

Split-edge runs push the almost flags in both directions. A flag that followed a single clock is caught when the wrong clock's edge moves it, or when the right edge fails to. The same pattern in single-owner mode is checked against the opposite expectation.

// File: rtl/flag_timing_pkg.sv
// Package: shared depth-code type and decode helpers for the flag timing stage.
// Assumes the depth codes arrive as two-bit fields with code 3 reserved.
package flag_timing_pkg;

    typedef enum logic [1:0] {
        BUF_ONE   = 2'd0,
        BUF_TWO   = 2'd1,
        BUF_THREE = 2'd2,
        BUF_RSVD  = 2'd3
    } buf_code_e;

    // A pair of codes is legal when neither is reserved and they match or one is single.
    function automatic logic pair_legal(input logic [1:0] a, input logic [1:0] b);
        return (a != BUF_RSVD) && (b != BUF_RSVD) &&
               ((a == BUF_ONE) || (b == BUF_ONE) || (a == b));
    endfunction

    // Stage count for one flag given its own code and its partner's code.
    function automatic logic [1:0] stage_count(input logic [1:0] own, input logic [1:0] other);
        logic [1:0] n;
        if (!pair_legal(own, other)) n = 2'd1;
        else                         n = own + 2'd1;
        return n;
    endfunction

endpackage

// File: rtl/flag_delay_line.sv
// Module: selectable-depth register chain for one boundary flag.
// Assumes nstg is held constant outside reset and is between 1 and MAX_STAGES.
// During reset every stage loads RST_VAL.
module flag_delay_line #(
    parameter int   MAX_STAGES = 3,
    parameter logic RST_VAL    = 1'b1,
    localparam int  SW         = $clog2(MAX_STAGES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] nstg,
    input  logic          din,
    output logic          dout
);

    logic [MAX_STAGES-1:0] stg;

    // Shift the raw condition through the chain; reset fills it with the idle value.
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= {MAX_STAGES{RST_VAL}};
        else        stg <= {stg[MAX_STAGES-2:0], din};
    end

    // Pick the tap that matches the configured stage count.
    always_comb begin
        dout = stg[0];
        for (int k = 0; k < MAX_STAGES; k++) begin
            if (32'(nstg) == k + 1) dout = stg[k];
        end
    end

    // Edges since reset was released, saturating; used only by the checks below.
    logic [SW-1:0] seen;
    always_ff @(posedge clk) begin
        if (!rst_n)                          seen <= '0;
        else if (seen != SW'(MAX_STAGES))    seen <= seen + 1'b1;
    end

    // R1
    rst_value_chk: assert property (@(posedge clk) !rst_n |=> dout == RST_VAL);

    // R3 R4
    depth_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nstg == SW'(1) && seen >= SW'(1)) |-> dout == $past(din, 1));

    // R3 R4
    depth_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nstg == SW'(2) && seen >= SW'(2)) |-> dout == $past(din, 2));

    // R3 R4
    depth_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nstg == SW'(3) && seen >= SW'(3)) |-> dout == $past(din, 3));

endmodule

// File: rtl/flag_split_edge.sv
// Module: one almost flag whose set and clear may belong to different clocks.
// In split-edge mode clk_a sets the flag and clk_b clears it. The two halves are
// a toggle pair and the flag is their difference. In single-owner mode the flag
// is the raw level sampled on clk_a.
// Assumes async_a and async_b hold the same latched mode bit, one per domain.
module flag_split_edge #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst_n,
    input  logic async_a,
    input  logic async_b,
    input  logic raw,
    output logic flag_o
);

    logic tog_a, tog_b, sync_q, split_flag;

    assign split_flag = tog_a ^ tog_b;

    // Set half: flip on clk_a when the condition appears while the flag is clear.
    always_ff @(posedge clk_a) begin
        if (!rst_n)                             tog_a <= RST_VAL;
        else if (async_a && raw && !split_flag) tog_a <= ~tog_a;
    end

    // Clear half: flip on clk_b when the condition is gone while the flag is set.
    always_ff @(posedge clk_b) begin
        if (!rst_n)                             tog_b <= 1'b0;
        else if (async_b && !raw && split_flag) tog_b <= ~tog_b;
    end

    // Single-owner copy: plain sample on the owning clock.
    always_ff @(posedge clk_a) begin
        if (!rst_n) sync_q <= RST_VAL;
        else        sync_q <= raw;
    end

    assign flag_o = async_a ? split_flag : sync_q;

    // R6 R7
    owner_follow_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        ($past(rst_n) && !async_a) |-> flag_o == $past(raw));

endmodule

// File: rtl/flag_timing_stage.sv
// Module: top of the flag timing stage. It latches the timing options per clock
// domain while reset is low, decodes the depth pair, and drives two delay lines
// and two split-edge almost flags.
// Assumes rst_n is held low for at least one edge of each clock.
module flag_timing_stage #(
    parameter int  MAX_STAGES = 3,
    localparam int SW         = $clog2(MAX_STAGES + 1)
) (
    input  logic       wr_clk,
    input  logic       rd_clk,
    input  logic       rst_n,
    input  logic       cfg_async_almost,
    input  logic [1:0] cfg_empty_buf,
    input  logic [1:0] cfg_full_buf,
    input  logic       raw_empty,
    input  logic       raw_full,
    input  logic       raw_almost_empty,
    input  logic       raw_almost_full,
    output logic       empty,
    output logic       full,
    output logic       almost_empty,
    output logic       almost_full
);
    import flag_timing_pkg::*;

    typedef struct packed {
        logic       async_almost;
        logic [1:0] ebuf;
        logic [1:0] fbuf;
    } cfg_t;

    cfg_t cfg_in, cfg_r, cfg_w;
    logic [SW-1:0] n_empty, n_full;

    assign cfg_in = '{async_almost: cfg_async_almost, ebuf: cfg_empty_buf, fbuf: cfg_full_buf};

    // Read-domain copy of the options, loaded only while reset is held.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) cfg_r <= cfg_in;
    end

    // Write-domain copy of the options, loaded only while reset is held.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) cfg_w <= cfg_in;
    end

    assign n_empty = SW'(stage_count(cfg_r.ebuf, cfg_r.fbuf));
    assign n_full  = SW'(stage_count(cfg_w.fbuf, cfg_w.ebuf));

    flag_delay_line #(.MAX_STAGES(MAX_STAGES), .RST_VAL(1'b1)) u_empty_dl (
        .clk(rd_clk), .rst_n(rst_n), .nstg(n_empty), .din(raw_empty), .dout(empty)
    );

    flag_delay_line #(.MAX_STAGES(MAX_STAGES), .RST_VAL(1'b0)) u_full_dl (
        .clk(wr_clk), .rst_n(rst_n), .nstg(n_full), .din(raw_full), .dout(full)
    );

    // Almost-empty: set by the read side, cleared by the write side.
    flag_split_edge #(.RST_VAL(1'b1)) u_aempty (
        .clk_a(rd_clk), .clk_b(wr_clk), .rst_n(rst_n),
        .async_a(cfg_r.async_almost), .async_b(cfg_w.async_almost),
        .raw(raw_almost_empty), .flag_o(almost_empty)
    );

    // Almost-full: set by the write side, cleared by the read side.
    flag_split_edge #(.RST_VAL(1'b0)) u_afull (
        .clk_a(wr_clk), .clk_b(rd_clk), .rst_n(rst_n),
        .async_a(cfg_w.async_almost), .async_b(cfg_r.async_almost),
        .raw(raw_almost_full), .flag_o(almost_full)
    );

    // R5
    depth_range_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (n_empty >= SW'(1)) && (n_empty <= SW'(MAX_STAGES)));

endmodule

// File: tb/sim_flag_timing_stage.sv
module sim_flag_timing_stage;

    logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
    logic cfg_async_almost = 1'b0;
    logic [1:0] cfg_empty_buf = 2'd0, cfg_full_buf = 2'd0;
    logic raw_empty = 1'b1, raw_full = 1'b0, raw_almost_empty = 1'b1, raw_almost_full = 1'b0;
    logic empty, full, almost_empty, almost_full;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    flag_timing_stage u0 (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .cfg_async_almost(cfg_async_almost), .cfg_empty_buf(cfg_empty_buf),
        .cfg_full_buf(cfg_full_buf), .raw_empty(raw_empty), .raw_full(raw_full),
        .raw_almost_empty(raw_almost_empty), .raw_almost_full(raw_almost_full),
        .empty(empty), .full(full), .almost_empty(almost_empty), .almost_full(almost_full)
    );

    // One 100 MHz cycle of each clock; results are sampled in the low half.
    task automatic pulse_w(); wr_clk = 1'b1; #5; wr_clk = 1'b0; #5; endtask
    task automatic pulse_r(); rd_clk = 1'b1; #5; rd_clk = 1'b0; #5; endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Apply reset with the given options, verify R1, then disturb the config pins (R2).
    task automatic do_reset(input logic am, input logic [1:0] eb, input logic [1:0] fb);
        rst_n = 1'b0;
        cfg_async_almost = am; cfg_empty_buf = eb; cfg_full_buf = fb;
        raw_empty = 1'b1; raw_full = 1'b0; raw_almost_empty = 1'b1; raw_almost_full = 1'b0;
        for (int i = 0; i < 2; i++) begin pulse_w(); pulse_r(); end
        check("R1 empty", empty, 1'b1);
        check("R1 full", full, 1'b0);
        check("R1 almost_empty", almost_empty, 1'b1);
        check("R1 almost_full", almost_full, 1'b0);
        rst_n = 1'b1;
        cfg_async_almost = ~am; cfg_empty_buf = 2'd2 - eb; cfg_full_buf = 2'd3;
    endtask

    // R3: empty needs n read edges; write edges never move it.
    task automatic t_empty_depth(input logic [1:0] eb, input logic [1:0] fb, input int n, input string req);
        do_reset(1'b0, eb, fb);
        raw_empty = 1'b0;
        for (int i = 1; i <= n; i++) begin
            pulse_w();
            check({req, " empty held on wr_clk"}, empty, (i > 1 && i - 1 >= n) ? 1'b0 : 1'b1);
            pulse_r();
            check({req, " empty latency"}, empty, (i >= n) ? 1'b0 : 1'b1);
        end
        raw_empty = 1'b1;
        for (int i = 1; i <= n; i++) begin
            pulse_r();
            check({req, " empty return"}, empty, (i >= n) ? 1'b1 : 1'b0);
        end
    endtask

    // R4: full needs n write edges; read edges never move it.
    task automatic t_full_depth(input logic [1:0] eb, input logic [1:0] fb, input int n, input string req);
        do_reset(1'b0, eb, fb);
        raw_full = 1'b1;
        for (int i = 1; i <= n; i++) begin
            pulse_r();
            check({req, " full held on rd_clk"}, full, (i > 1 && i - 1 >= n) ? 1'b1 : 1'b0);
            pulse_w();
            check({req, " full latency"}, full, (i >= n) ? 1'b1 : 1'b0);
        end
    endtask

    // R8 R9: split-edge ownership of both almost flags.
    task automatic t_split_edge();
        do_reset(1'b1, 2'd0, 2'd0);
        raw_almost_empty = 1'b0;
        pulse_r(); check("R8 ae not cleared by rd_clk", almost_empty, 1'b1);
        pulse_w(); check("R8 ae cleared by wr_clk", almost_empty, 1'b0);
        raw_almost_empty = 1'b1;
        pulse_w(); check("R8 ae not set by wr_clk", almost_empty, 1'b0);
        pulse_r(); check("R8 ae set by rd_clk", almost_empty, 1'b1);
        raw_almost_full = 1'b1;
        pulse_r(); check("R9 af not set by rd_clk", almost_full, 1'b0);
        pulse_w(); check("R9 af set by wr_clk", almost_full, 1'b1);
        raw_almost_full = 1'b0;
        pulse_w(); check("R9 af not cleared by wr_clk", almost_full, 1'b1);
        pulse_r(); check("R9 af cleared by rd_clk", almost_full, 1'b0);
    endtask

    // R6 R7 R10: single-owner almost flags, with deep boundary buffering selected.
    task automatic t_owner_mode();
        do_reset(1'b0, 2'd2, 2'd2);
        raw_almost_empty = 1'b0;
        pulse_w(); check("R6 ae ignores wr_clk", almost_empty, 1'b1);
        pulse_r(); check("R10 ae one rd edge", almost_empty, 1'b0);
        raw_almost_full = 1'b1;
        pulse_r(); check("R7 af ignores rd_clk", almost_full, 1'b0);
        pulse_w(); check("R10 af one wr edge", almost_full, 1'b1);
        raw_almost_full = 1'b0;
        pulse_r(); check("R7 af held on rd_clk", almost_full, 1'b1);
        pulse_w(); check("R7 af clears on wr_clk", almost_full, 1'b0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_empty_depth(2'd0, 2'd0, 1, "R3 code0");
        t_empty_depth(2'd1, 2'd0, 2, "R3 code1");
        t_empty_depth(2'd2, 2'd0, 3, "R3 code2 R2");
        t_full_depth(2'd0, 2'd1, 2, "R4 code1");
        t_full_depth(2'd0, 2'd2, 3, "R4 code2");
        t_full_depth(2'd1, 2'd1, 2, "R5 matched pair");
        t_empty_depth(2'd2, 2'd1, 1, "R5 mixed pair");
        t_full_depth(2'd2, 2'd1, 1, "R5 mixed pair");
        t_empty_depth(2'd0, 2'd3, 1, "R5 reserved code");
        t_split_edge();
        t_owner_mode();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule